// File: doc/BRIEF.md
# Video Test Pattern Generator

This block paints synthetic test images into a video pipeline whose timing is produced elsewhere. It watches an external line-enable strobe and a frame-end pulse, keeps its own column and row position from their edges, and for every enabled pixel emits a 24-bit colour made of 8-bit red, green and blue channels. Next to the colour channels it also emits one 8-bit sample per pixel in a camera-style colour-filter mosaic. A downstream stage can therefore be fed either full-colour pixels or raw sensor-like data without a real camera attached.

Eight images can be chosen with a 3-bit code:
- a checkerboard of coloured boxes;
- three solid fills;
- colour bars in either direction;
- grey ramps in either direction.

The code is taken only when a frame-end pulse arrives, so one frame never shows two images. The resolution and the mosaic order are fixed when the block is built.

The pixel path is two registers deep. The valid flag and the frame-end output are delayed by the same two cycles as the pixels. There is no back-pressure: the timing source sets the pixel rate, so the receiver has to take every beat for which the valid flag is high.

Top module: `vid_pattern_gen`

## Requirements
- R1: While reset is low and in the first cycle after it, every output is zero. The reset is active low and asynchronous.
- R2: `pix_valid_o` equals `line_en_i` delayed by two clock cycles, and `frame_end_o` equals `frame_end_i` delayed by two clock cycles.
- R3: When `pix_valid_o` is low, `red_o`, `green_o`, `blue_o` and `mosaic_o` are all zero.
- R4: Column position.
  - The column starts at 0 on the first enabled cycle of a line and goes up by one on each enabled cycle.
  - It returns to 0 once `line_en_i` falls.
  - It saturates at H_RES-1 and does not wrap.
- R5: Row position.
  - The row goes up by one on each falling edge of `line_en_i`.
  - It returns to 0 while `frame_end_i` is high.
  - It saturates at V_RES-1.
- R6: `pattern_i` is captured only in a cycle where `frame_end_i` is high, and that captured value selects the image for the following lines. The code taken at reset is 0.
- R7: Codes 1, 2 and 3 fill the frame with pure red (FF,00,00), pure green (00,FF,00) and pure blue (00,00,FF).
- R8: Code 4 gives eight vertical bars.
  - The bar index is column/(H_RES/8), limited to 7.
  - Bar index k maps to R = NOT k[1], G = NOT k[2], B = NOT k[0], each bit widened to 00 or FF.
  - In index order this is white, yellow, cyan, green, magenta, red, blue, black.
- R9: Code 5 gives eight horizontal bars with the same colour table as R8, indexed by row/(V_RES/8), limited to 7.
- R10: Code 0 gives an 8 by 8 grid of boxes. The colour index of each box is the column bar index XOR the row bar index.
- R11: Grey ramps put the same level on R, G and B.
  - Code 6 uses the level floor(row*255/(V_RES-1)), so it is constant along each line.
  - Code 7 uses the level floor(column*255/(H_RES-1)).
- R12: `mosaic_o` carries one channel of the pixel, chosen by {row bit 0, column bit 0}.
  - BAYER_ORDER 0 (RGGB) picks R, G, G, B for sites 00, 01, 10, 11.
  - BAYER_ORDER 1 (BGGR) picks B, G, G, R.
  - BAYER_ORDER 2 (GRBG) picks G, R, B, G.
  - BAYER_ORDER 3 (GBRG) picks G, B, R, G.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_en_i | input | 1 | High for each active pixel of a line |
| frame_end_i | input | 1 | End-of-frame pulse; also captures the pattern code |
| pattern_i | input | 3 | Pattern code |
| pix_valid_o | output | 1 | Pixel valid, two cycles after line_en_i |
| frame_end_o | output | 1 | frame_end_i delayed by two cycles |
| red_o | output | 8 | Red channel |
| green_o | output | 8 | Green channel |
| blue_o | output | 8 | Blue channel |
| mosaic_o | output | 8 | Raw colour-filter sample |

## Verification
The embedded properties assume that `frame_end_i` is pulsed only while `line_en_i` is low. If the two were high together, the code change would overlap a line and the row clear would overlap a row step. They also assume that lines are separated by at least one low cycle of `line_en_i`. The stimulus follows both rules: each frame-end is a single-cycle pulse in blanking, each line is followed by four idle cycles, and `pattern_i` is deliberately moved away from the captured code in the middle of a frame. Over-long lines and frames with too many lines are driven on purpose, to reach the saturation limits.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  typedef enum logic [2:0] {
    PAT_BOXES = 3'd0,
    PAT_RED   = 3'd1,
    PAT_GREEN = 3'd2,
    PAT_BLUE  = 3'd3,
    PAT_VBARS = 3'd4,
    PAT_HBARS = 3'd5,
    PAT_HRAMP = 3'd6,
    PAT_VRAMP = 3'd7
  } pat_e;

  typedef enum logic [1:0] {
    MOS_RGGB = 2'd0,
    MOS_BGGR = 2'd1,
    MOS_GRBG = 2'd2,
    MOS_GBRG = 2'd3
  } mosaic_e;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  // Saturated bar palette: each channel is one inverted index bit.
  function automatic rgb_t bar_colour(input logic [2:0] idx);
    rgb_t c;
    c.r = {8{~idx[1]}};
    c.g = {8{~idx[2]}};
    c.b = {8{~idx[0]}};
    return c;
  endfunction

endpackage

// File: rtl/tpg_position.sv
module tpg_position #(
  parameter int H_RES = 64,
  parameter int V_RES = 16,
  parameter int HW    = 6,
  parameter int VW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          line_en_i,
  input  logic          frame_end_i,
  output logic [HW-1:0] col_o,
  output logic [VW-1:0] row_o
);

  localparam logic [HW-1:0] COL_MAX = HW'(H_RES - 1);
  localparam logic [VW-1:0] ROW_MAX = VW'(V_RES - 1);

  logic en_q;
  logic line_fell;

  assign line_fell = en_q & ~line_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      col_o <= '0;
      row_o <= '0;
    end else begin
      en_q <= line_en_i;

      if (line_en_i) begin
        if (col_o != COL_MAX) col_o <= col_o + 1'b1;
      end else if (line_fell) begin
        col_o <= '0;
      end

      if (frame_end_i) begin
        row_o <= '0;
      end else if (line_fell && row_o != ROW_MAX) begin
        row_o <= row_o + 1'b1;
      end
    end
  end

  // R4: the column is back at zero after a line ends
  a_r4_col_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_fell |=> (col_o == '0));

  // R4: the column never passes its last position
  a_r4_col_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_en_i && col_o == COL_MAX) |=> (col_o == COL_MAX));

  // R5: frame end brings the row back to zero
  a_r5_row_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_i |=> (row_o == '0));

endmodule

// File: rtl/tpg_colour.sv
module tpg_colour
  import tpg_pkg::*;
#(
  parameter int H_RES = 64,
  parameter int V_RES = 16,
  parameter int HW    = 6,
  parameter int VW    = 4
) (
  input  pat_e          pat_i,
  input  logic [HW-1:0] col_i,
  input  logic [VW-1:0] row_i,
  output rgb_t          pix_o
);

  localparam int unsigned COL_BAND = (H_RES >= 8) ? H_RES / 8 : 1;
  localparam int unsigned ROW_BAND = (V_RES >= 8) ? V_RES / 8 : 1;
  localparam int unsigned COL_DEN  = (H_RES > 1) ? H_RES - 1 : 1;
  localparam int unsigned ROW_DEN  = (V_RES > 1) ? V_RES - 1 : 1;

  logic [31:0] col_band;
  logic [31:0] row_band;
  logic [31:0] col_grey;
  logic [31:0] row_grey;
  logic [2:0]  cb;
  logic [2:0]  rb;

  always_comb begin
    col_band = 32'(col_i) / COL_BAND;
    row_band = 32'(row_i) / ROW_BAND;
    cb       = (col_band > 32'd7) ? 3'd7 : col_band[2:0];
    rb       = (row_band > 32'd7) ? 3'd7 : row_band[2:0];
    col_grey = (32'(col_i) * 32'd255) / COL_DEN;
    row_grey = (32'(row_i) * 32'd255) / ROW_DEN;

    unique case (pat_i)
      PAT_BOXES: pix_o = bar_colour(cb ^ rb);
      PAT_RED:   pix_o = '{r: 8'hFF, g: 8'h00, b: 8'h00};
      PAT_GREEN: pix_o = '{r: 8'h00, g: 8'hFF, b: 8'h00};
      PAT_BLUE:  pix_o = '{r: 8'h00, g: 8'h00, b: 8'hFF};
      PAT_VBARS: pix_o = bar_colour(cb);
      PAT_HBARS: pix_o = bar_colour(rb);
      PAT_HRAMP: pix_o = '{r: row_grey[7:0], g: row_grey[7:0], b: row_grey[7:0]};
      PAT_VRAMP: pix_o = '{r: col_grey[7:0], g: col_grey[7:0], b: col_grey[7:0]};
      default:   pix_o = '0;
    endcase
  end

endmodule

// File: rtl/tpg_mosaic.sv
module tpg_mosaic
  import tpg_pkg::*;
#(
  parameter mosaic_e ORDER = MOS_RGGB
) (
  input  rgb_t       pix_i,
  input  logic       row_odd_i,
  input  logic       col_odd_i,
  output logic [7:0] sample_o
);

  logic [1:0] site;
  assign site = {row_odd_i, col_odd_i};

  generate
    if (ORDER == MOS_RGGB) begin : g_rggb
      always_comb begin
        unique case (site)
          2'b00:   sample_o = pix_i.r;
          2'b11:   sample_o = pix_i.b;
          default: sample_o = pix_i.g;
        endcase
      end
    end else if (ORDER == MOS_BGGR) begin : g_bggr
      always_comb begin
        unique case (site)
          2'b00:   sample_o = pix_i.b;
          2'b11:   sample_o = pix_i.r;
          default: sample_o = pix_i.g;
        endcase
      end
    end else if (ORDER == MOS_GRBG) begin : g_grbg
      always_comb begin
        unique case (site)
          2'b01:   sample_o = pix_i.r;
          2'b10:   sample_o = pix_i.b;
          default: sample_o = pix_i.g;
        endcase
      end
    end else begin : g_gbrg
      always_comb begin
        unique case (site)
          2'b01:   sample_o = pix_i.b;
          2'b10:   sample_o = pix_i.r;
          default: sample_o = pix_i.g;
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/vid_pattern_gen.sv
module vid_pattern_gen
  import tpg_pkg::*;
#(
  parameter int      H_RES       = 64,
  parameter int      V_RES       = 16,
  parameter mosaic_e BAYER_ORDER = MOS_RGGB
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       line_en_i,
  input  logic       frame_end_i,
  input  logic [2:0] pattern_i,
  output logic       pix_valid_o,
  output logic       frame_end_o,
  output logic [7:0] red_o,
  output logic [7:0] green_o,
  output logic [7:0] blue_o,
  output logic [7:0] mosaic_o
);

  localparam int HW = (H_RES > 1) ? $clog2(H_RES) : 1;
  localparam int VW = (V_RES > 1) ? $clog2(V_RES) : 1;

  logic [HW-1:0] col;
  logic [VW-1:0] row;

  tpg_position #(.H_RES(H_RES), .V_RES(V_RES), .HW(HW), .VW(VW)) u_position (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_en_i   (line_en_i),
    .frame_end_i (frame_end_i),
    .col_o       (col),
    .row_o       (row)
  );

  // Stage 1: position and strobes of the current pixel, plus the frame's code
  logic          s1_en;
  logic          s1_fe;
  logic [HW-1:0] s1_col;
  logic [VW-1:0] s1_row;
  pat_e          pat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_en  <= 1'b0;
      s1_fe  <= 1'b0;
      s1_col <= '0;
      s1_row <= '0;
      pat_q  <= PAT_BOXES;
    end else begin
      s1_en  <= line_en_i;
      s1_fe  <= frame_end_i;
      s1_col <= col;
      s1_row <= row;
      if (frame_end_i) pat_q <= pat_e'(pattern_i);
    end
  end

  rgb_t       pix;
  logic [7:0] sample;

  tpg_colour #(.H_RES(H_RES), .V_RES(V_RES), .HW(HW), .VW(VW)) u_colour (
    .pat_i (pat_q),
    .col_i (s1_col),
    .row_i (s1_row),
    .pix_o (pix)
  );

  tpg_mosaic #(.ORDER(BAYER_ORDER)) u_mosaic (
    .pix_i     (pix),
    .row_odd_i (s1_row[0]),
    .col_odd_i (s1_col[0]),
    .sample_o  (sample)
  );

  // Stage 2: output registers, blanked to zero outside active pixels
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_valid_o <= 1'b0;
      frame_end_o <= 1'b0;
      red_o       <= '0;
      green_o     <= '0;
      blue_o      <= '0;
      mosaic_o    <= '0;
    end else begin
      pix_valid_o <= s1_en;
      frame_end_o <= s1_fe;
      if (s1_en) begin
        red_o    <= pix.r;
        green_o  <= pix.g;
        blue_o   <= pix.b;
        mosaic_o <= sample;
      end else begin
        red_o    <= '0;
        green_o  <= '0;
        blue_o   <= '0;
        mosaic_o <= '0;
      end
    end
  end

  // Cycles since reset, so that two-deep history checks start only once both samples are valid
  logic [1:0] age;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  a_r2_strobe_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd2) |-> (pix_valid_o == $past(line_en_i, 2) &&
                       frame_end_o == $past(frame_end_i, 2)));

  a_r3_blank_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_o |-> (red_o == 8'h00 && green_o == 8'h00 &&
                      blue_o == 8'h00 && mosaic_o == 8'h00));

  a_r6_code_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end_i |=> $stable(pat_q));

  a_r12_mosaic_is_channel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> (mosaic_o == red_o || mosaic_o == green_o || mosaic_o == blue_o));

endmodule

// File: tb/test_vid_pattern_gen.sv
module test_vid_pattern_gen;

  localparam int CLK_PERIOD = 10;
  localparam int H = 64;
  localparam int V = 16;
  localparam int NPROBE = 19;

  // Probe layout: {code[3], col[8], row[8], rgb[24], mosaic[8]}; mosaic order is RGGB
  localparam logic [50:0] PROBES [NPROBE] = '{
    {3'd0, 8'd0,  8'd0,  24'hFFFFFF, 8'hFF},
    {3'd0, 8'd8,  8'd0,  24'hFFFF00, 8'hFF},
    {3'd0, 8'd8,  8'd2,  24'hFFFFFF, 8'hFF},
    {3'd0, 8'd63, 8'd4,  24'hFF0000, 8'h00},
    {3'd1, 8'd5,  8'd3,  24'hFF0000, 8'h00},
    {3'd2, 8'd2,  8'd1,  24'h00FF00, 8'hFF},
    {3'd3, 8'd3,  8'd1,  24'h0000FF, 8'hFF},
    {3'd4, 8'd16, 8'd9,  24'h00FFFF, 8'hFF},
    {3'd4, 8'd63, 8'd0,  24'h000000, 8'h00},
    {3'd5, 8'd40, 8'd8,  24'hFF00FF, 8'hFF},
    {3'd5, 8'd1,  8'd13, 24'h0000FF, 8'hFF},
    {3'd6, 8'd0,  8'd0,  24'h000000, 8'h00},
    {3'd6, 8'd0,  8'd15, 24'hFFFFFF, 8'hFF},
    {3'd6, 8'd2,  8'd5,  24'h555555, 8'h55},
    {3'd7, 8'd63, 8'd0,  24'hFFFFFF, 8'hFF},
    {3'd7, 8'd21, 8'd0,  24'h555555, 8'h55},
    {3'd7, 8'd1,  8'd1,  24'h040404, 8'h04},
    {3'd3, 8'd60, 8'd14, 24'h0000FF, 8'h00},
    {3'd1, 8'd0,  8'd0,  24'hFF0000, 8'hFF}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_en = 1'b0;
  logic       frame_end = 1'b0;
  logic [2:0] pattern = 3'd0;
  logic       pix_valid;
  logic       frame_end_q;
  logic [7:0] red, green, blue, mosaic;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vid_pattern_gen #(.H_RES(H), .V_RES(V)) i_vid_pattern_gen (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .line_en_i   (line_en),
    .frame_end_i (frame_end),
    .pattern_i   (pattern),
    .pix_valid_o (pix_valid),
    .frame_end_o (frame_end_q),
    .red_o       (red),
    .green_o     (green),
    .blue_o      (blue),
    .mosaic_o    (mosaic)
  );

  // Output-side position tracker, built only from the port timing rules
  logic [31:0] frame_px [V][H];
  logic [31:0] last_px = '0;
  int  mon_col = 0;
  int  mon_row = 0;
  logic mon_prev = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      mon_col  = 0;
      mon_row  = 0;
      mon_prev = 1'b0;
    end else begin
      if (frame_end_q) mon_row = 0;
      if (pix_valid) begin
        last_px = {mosaic, red, green, blue};
        if (mon_col < H && mon_row < V) frame_px[mon_row][mon_col] = last_px;
        mon_col++;
      end else if (mon_prev) begin
        mon_col = 0;
        mon_row++;
      end
      mon_prev = pix_valid;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic frame_pulse(input logic [2:0] code);
    @(negedge clk);
    pattern   = code;
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    pattern   = code ^ 3'b101;  // moved away mid-frame; must be ignored (R6)
    repeat (3) @(negedge clk);
  endtask

  task automatic drive_line(input int n);
    for (int i = 0; i < n; i++) begin
      line_en = 1'b1;
      @(negedge clk);
    end
    line_en = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  function automatic string tag_for(input logic [2:0] code);
    case (code)
      3'd0:    return "R10";
      3'd4:    return "R8";
      3'd5:    return "R9";
      3'd6,
      3'd7:    return "R11";
      default: return "R7";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {22'd0, pix_valid, frame_end_q, red, green, blue, mosaic}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {22'd0, pix_valid, frame_end_q, red, green, blue, mosaic}, 32'd0);

    // Vector table: one frame per code, then every probe of that code
    for (int code = 0; code < 8; code++) begin
      frame_pulse(3'(code));
      for (int l = 0; l < V; l++) drive_line(H);
      for (int p = 0; p < NPROBE; p++) begin
        logic [50:0] e;
        e = PROBES[p];
        if (e[50:48] == 3'(code)) begin
          check(tag_for(e[50:48]), {8'd0, frame_px[e[39:32]][e[47:40]][23:0]}, {8'd0, e[31:8]});
          check("R12 mosaic", {24'd0, frame_px[e[39:32]][e[47:40]][31:24]}, {24'd0, e[7:0]});
        end
      end
    end

    // R3: blanking between lines of a white-box frame
    frame_pulse(3'd0);
    drive_line(H);
    check("R3 blank outputs", {8'd0, red, green, blue}, 32'd0);
    check("R3 blank mosaic", {24'd0, mosaic}, 32'd0);

    // R2: two-cycle strobe delays
    @(negedge clk);
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    check("R2 frame end one cycle", {31'd0, frame_end_q}, 32'd0);
    @(negedge clk);
    check("R2 frame end two cycles", {31'd0, frame_end_q}, 32'd1);
    @(negedge clk);
    line_en = 1'b1;
    @(negedge clk);
    line_en = 1'b0;
    check("R2 valid one cycle", {31'd0, pix_valid}, 32'd0);
    @(negedge clk);
    check("R2 valid two cycles", {31'd0, pix_valid}, 32'd1);
    repeat (4) @(negedge clk);

    // R4: over-long line, horizontal ramp stays at full scale
    frame_pulse(3'd7);
    drive_line(H + 6);
    check("R4 column saturates", {24'd0, last_px[23:16]}, 32'hFF);
    drive_line(H);
    check("R4 column restarts", {24'd0, frame_px[1][0][23:16]}, 32'h00);

    // R5: too many lines, vertical ramp stays at full scale
    frame_pulse(3'd6);
    for (int l = 0; l < V + 4; l++) drive_line(H);
    check("R5 row saturates", {24'd0, last_px[23:16]}, 32'hFF);
    frame_pulse(3'd6);
    drive_line(H);
    check("R5 row cleared by frame end", {24'd0, last_px[23:16]}, 32'h00);

    // R6: code latched at frame end survives a mid-frame change
    frame_pulse(3'd2);
    pattern = 3'd3;
    drive_line(H);
    check("R6 code held", {8'd0, last_px[23:0]}, 32'h0000FF00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule